// File: doc/BRIEF.md
# Delta-Sigma Bitstream Capture Interface

This block makes the conversion clock for an external second-order delta-sigma modulator that runs from an externally supplied clock. It then recovers the modulator's one-bit output stream in the system clock domain. The modulator clock comes from an even divider of the fast system clock, so its high and low phases are always equal. A divide setting picks the half-period in system cycles. The setting is clamped so that the modulator clock stays between 500 kHz and 20 MHz.

The modulator clock runs at twice the modulator sampling rate. The modulator therefore yields one new data bit every two modulator clock periods. The block samples the data line only on every second falling edge of the clock it generates. A phase toggle, cleared by reset, makes the second falling edge after reset the first capture edge. The sampled line then passes through a short synchronizer. The capture strobe is delayed by the same number of stages, so the recovered bit is exactly the line value at the capture edge.

Each recovered bit is presented with a valid pulse one system cycle wide. The bit is held until the next capture. The density of ones in the stream follows the analog input, and the stream has no fixed frequency or duty cycle. Decimation filtering is done downstream.

Top module: `ds_bitstream_if`

## Requirements
- R1: After the first low phase that follows reset, `mclk_o` stays high for exactly h system cycles and low for exactly h system cycles, where h is the effective half-period. This gives a period of 2h and a 50% duty cycle.
- R2: h equals `half_div_i` clamped to the range [HALF_MIN, HALF_MAX]. HALF_MIN is ceil(SYS_CLK_HZ / (2*MCLK_MAX_HZ)) and HALF_MAX is floor(SYS_CLK_HZ / (2*MCLK_MIN_HZ)), which gives 3 and 100 with the default parameters.
- R3: Consecutive `bit_valid_o` pulses are exactly 4h system cycles apart, so there is one capture per two modulator clock periods.
- R4: The first capture uses the second falling edge of `mclk_o` after reset release. Counting the first rising system clock edge after release as edge 1, `bit_valid_o` is first high after edge 4h + SYNC_STAGES (SYNC_STAGES is 2 by default).
- R5: `bit_valid_o` is high for exactly one system cycle per capture, and `bit_o` does not change between captures.
- R6: `bit_o` equals the value `mdata_i` had at the system clock edge on which `mclk_o` falls for a capture. A data line that changes just after each capture edge is therefore recovered bit for bit and in order.
- R7: A new `half_div_i` value takes effect only at a falling edge of `mclk_o`. A high phase already under way keeps its old length, and the following low phase uses the new length.
- R8: While `rst_ni` is low, `mclk_o`, `bit_o` and `bit_valid_o` are all 0, including when reset is applied in the middle of operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| half_div_i | input | SET_W | Requested modulator clock half-period in system cycles |
| mdata_i | input | 1 | Serial data line from the modulator |
| mclk_o | output | 1 | Conversion clock to the modulator |
| bit_o | output | 1 | Most recently captured data bit |
| bit_valid_o | output | 1 | One-cycle strobe marking a new bit |

## Verification
The data line is driven with all-zero, all-one, alternating, sparse edge-bit and mixed 16-bit patterns. Each pattern changes the line right after every capture edge. A block that samples the wrong falling edge or the wrong phase therefore returns a shifted or merged sequence, and this is visible even in the constant patterns through the timing of the first strobe.

The divide settings include values below the minimum, at the minimum, in the middle and above the maximum. These separate correct clamping from a pass-through divider. A setting changed during a high phase shows whether the new setting waits for the next falling edge. A reset applied mid-stream checks that all outputs return to their idle values.

// File: rtl/ds_cap_pkg.sv
package ds_cap_pkg;

  // Limit a requested half-period to the legal window.
  function automatic int unsigned clamp_half(input int unsigned req,
                                             input int unsigned lo,
                                             input int unsigned hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

endpackage

// File: rtl/ds_mclk_gen.sv
module ds_mclk_gen #(
  parameter int SET_W    = 8,
  parameter int HALF_MIN = 3,
  parameter int HALF_MAX = 100,
  parameter int CNT_W    = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] half_div_i,
  output logic             mclk_o,
  output logic             fall_evt_o
);
  import ds_cap_pkg::*;

  logic [CNT_W-1:0] cnt_q, half_q, half_req, half_use;
  logic             mclk_q, start_q, wrap;

  always_comb begin
    half_req   = CNT_W'(clamp_half(32'(half_div_i), HALF_MIN, HALF_MAX));
    half_use   = start_q ? half_req : half_q;
    wrap       = (cnt_q == half_use - 1'b1);
    fall_evt_o = wrap & mclk_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      mclk_q  <= 1'b0;
      half_q  <= CNT_W'(HALF_MIN);
      start_q <= 1'b1;
    end else begin
      start_q <= 1'b0;
      if (wrap) begin
        cnt_q  <= '0;
        mclk_q <= ~mclk_q;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
      // setting accepted only at a period boundary (falling edge)
      if (start_q || fall_evt_o) half_q <= half_req;
    end
  end

  assign mclk_o = mclk_q;

  AST_HALF_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_q >= CNT_W'(HALF_MIN)) && (half_q <= CNT_W'(HALF_MAX))); // R2

endmodule

// File: rtl/ds_edge_phase.sv
module ds_edge_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mclk_i,
  input  logic fall_evt_i,
  output logic cap_evt_o
);

  logic phase_q;

  // phase 0 after reset: first falling edge skipped, second captures
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         phase_q <= 1'b0;
    else if (fall_evt_i) phase_q <= ~phase_q;
  end

  assign cap_evt_o = fall_evt_i & phase_q;

  AST_CAP_WHILE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_o |-> mclk_i); // R4

  AST_CAP_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_o |=> !mclk_i); // R6

endmodule

// File: rtl/ds_bit_capture.sv
module ds_bit_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  input  logic cap_i,
  output logic bit_o,
  output logic valid_o
);

  logic data_s, cap_s;
  logic bit_q, valid_q;

  if (SYNC_STAGES == 0) begin : g_direct
    assign data_s = data_i;
    assign cap_s  = cap_i;
  end else begin : g_sync
    logic [SYNC_STAGES-1:0] dq, cq;
    // strobe delayed by the same depth as the data path
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dq <= '0;
        cq <= '0;
      end else begin
        dq[0] <= data_i;
        cq[0] <= cap_i;
        for (int i = 1; i < SYNC_STAGES; i++) begin
          dq[i] <= dq[i-1];
          cq[i] <= cq[i-1];
        end
      end
    end
    assign data_s = dq[SYNC_STAGES-1];
    assign cap_s  = cq[SYNC_STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= cap_s;
      if (cap_s) bit_q <= data_s;
    end
  end

  assign bit_o   = bit_q;
  assign valid_o = valid_q;

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R5

  AST_BIT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(bit_o)); // R5

endmodule

// File: rtl/ds_bitstream_if.sv
module ds_bitstream_if #(
  parameter int SYS_CLK_HZ  = 100_000_000,
  parameter int MCLK_MAX_HZ = 20_000_000,
  parameter int MCLK_MIN_HZ = 500_000,
  parameter int SET_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] half_div_i,
  input  logic             mdata_i,
  output logic             mclk_o,
  output logic             bit_o,
  output logic             bit_valid_o
);

  localparam int HALF_MIN = (SYS_CLK_HZ + 2 * MCLK_MAX_HZ - 1) / (2 * MCLK_MAX_HZ);
  localparam int HALF_MAX = SYS_CLK_HZ / (2 * MCLK_MIN_HZ);
  localparam int CNT_W    = $clog2(HALF_MAX + 1);

  logic fall_evt, cap_evt;

  ds_mclk_gen #(
    .SET_W   (SET_W),
    .HALF_MIN(HALF_MIN),
    .HALF_MAX(HALF_MAX),
    .CNT_W   (CNT_W)
  ) i_mclk_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .half_div_i(half_div_i),
    .mclk_o    (mclk_o),
    .fall_evt_o(fall_evt)
  );

  ds_edge_phase i_edge_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mclk_i    (mclk_o),
    .fall_evt_i(fall_evt),
    .cap_evt_o (cap_evt)
  );

  ds_bit_capture #(
    .SYNC_STAGES(SYNC_STAGES)
  ) i_bit_capture (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (mdata_i),
    .cap_i  (cap_evt),
    .bit_o  (bit_o),
    .valid_o(bit_valid_o)
  );

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> (!mclk_o && !bit_o && !bit_valid_o)); // R8

endmodule

// File: tb/test_ds_bitstream_if.sv
module test_ds_bitstream_if;

  localparam int SYNC  = 2;
  localparam int H_MIN = 3;
  localparam int H_MAX = 100;

  typedef struct packed {
    logic [7:0]  div;
    logic [15:0] pat;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{div: 8'd5,   pat: 16'hA5C3},
    '{div: 8'd3,   pat: 16'h0000},
    '{div: 8'd1,   pat: 16'hFFFF},  // clamps to 3
    '{div: 8'd0,   pat: 16'h8001},  // clamps to 3
    '{div: 8'd16,  pat: 16'h5555},
    '{div: 8'd250, pat: 16'h1234},  // clamps to 100
    '{div: 8'd100, pat: 16'hC0DE}
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] half_div = 8'd5;
  logic       mdata = 1'b0;
  logic       mclk_o, bit_o, bit_valid_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  ds_bitstream_if i_ds_bitstream_if (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .half_div_i (half_div),
    .mdata_i    (mdata),
    .mclk_o     (mclk_o),
    .bit_o      (bit_o),
    .bit_valid_o(bit_valid_o)
  );

  function automatic int exp_half(input int d);
    if (d < H_MIN) return H_MIN;
    if (d > H_MAX) return H_MAX;
    return d;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply_reset(input logic [7:0] d, input logic first_bit);
    @(negedge clk);
    rst_ni   = 1'b0;
    half_div = d;
    mdata    = first_bit;
    repeat (3) @(negedge clk);
    // R8: idle outputs in reset
    chk(mclk_o === 1'b0, "R8 mclk_o in reset", int'(mclk_o), 0);
    chk(bit_valid_o === 1'b0, "R8 bit_valid_o in reset", int'(bit_valid_o), 0);
    chk(bit_o === 1'b0, "R8 bit_o in reset", int'(bit_o), 0);
    rst_ni = 1'b1;
  endtask

  task automatic run_row(input logic [7:0] d, input logic [15:0] pat);
    int h;
    h = exp_half(int'(d));
    apply_reset(d, pat[0]);
    fork
      begin : drv
        int falls = 0;
        while (falls < 32) begin
          @(negedge mclk_o);
          falls++;
          if ((falls % 2 == 0) && (falls / 2 < 16)) begin
            #1 mdata = pat[falls/2];
          end
        end
      end
      begin : mon
        int   e = 0, ncap = 0, last_e = 0, runs = 0, run_len = 0;
        logic lvl = 1'b0, held = 1'b0, prev_v = 1'b0;
        bit   first_run = 1'b1, hold_ok = 1'b1;
        while (ncap < 16) begin
          @(negedge clk);
          e++;
          if (mclk_o !== lvl) begin
            if (!first_run && runs < 4) begin
              chk(run_len == h, "R1/R2 mclk phase length", run_len, h);
              runs++;
            end
            first_run = 1'b0;
            lvl = mclk_o;
            run_len = 1;
          end else begin
            run_len++;
          end
          if (prev_v) chk(bit_valid_o === 1'b0, "R5 valid width", int'(bit_valid_o), 0);
          if (!bit_valid_o && ncap > 0 && bit_o !== held) hold_ok = 1'b0;
          if (bit_valid_o === 1'b1) begin
            if (ncap == 0) chk(e == 4*h + SYNC, "R4 first capture edge", e, 4*h + SYNC);
            else chk(e - last_e == 4*h, "R3 capture spacing", e - last_e, 4*h);
            chk(bit_o === pat[ncap], "R6 recovered bit", int'(bit_o), int'(pat[ncap]));
            last_e = e;
            held = bit_o;
            ncap++;
          end
          prev_v = bit_valid_o;
        end
        chk(hold_ok, "R5 bit held between captures", int'(hold_ok), 1);
      end
    join
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int n;
    // Vector table: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) run_row(VEC[i].div, VEC[i].pat);

    // R7: setting changed mid high phase waits for the falling edge
    apply_reset(8'd5, 1'b0);
    @(posedge mclk_o);
    n = 0;
    while (1) begin
      @(negedge clk);
      if (!mclk_o) break;
      n++;
      if (n == 2) half_div = 8'd8;
    end
    chk(n == 5, "R7 high phase keeps old length", n, 5);
    n = 1;
    while (1) begin
      @(negedge clk);
      if (mclk_o) break;
      n++;
    end
    chk(n == 8, "R7 low phase uses new length", n, 8);
    n = 1;
    while (1) begin
      @(negedge clk);
      if (!mclk_o) break;
      n++;
    end
    chk(n == 8, "R7 next high phase uses new length", n, 8);

    // R8: reset in mid-stream with a captured 1 on bit_o
    apply_reset(8'd3, 1'b1);
    repeat (4*3 + SYNC + 3) @(negedge clk);
    chk(bit_o === 1'b1, "R6 captured one before reset", int'(bit_o), 1);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(bit_o === 1'b0, "R8 bit_o cleared by async reset", int'(bit_o), 0);
    chk(mclk_o === 1'b0, "R8 mclk_o cleared by async reset", int'(mclk_o), 0);
    chk(bit_valid_o === 1'b0, "R8 bit_valid_o cleared by async reset", int'(bit_valid_o), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule